// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block watches a processor's execution against four programmable debug breakpoint slots and reports which slots hit. Every slot has a 32-bit address register and a 4-bit group in a shared 32-bit control word. Two enable bits per slot (local and global) are ORed together. Each slot also has a kind field (instruction execute, data write, data read/write, or I/O read/write) and a length field that gives the width of the I/O window.

Three kinds of event are evaluated. An ordinary check compares instruction slots with the current instruction pointer and takes per-slot watch-hit flags for the data slots. These flags come from an external memory-access detector. An I/O access tests I/O slots for range overlap with the accessed port bytes. A single-step request runs a forced check and always traps. The block holds the low four hit bits and the single-step bit of the debug status. It emits a one-cycle debug-exception pulse on the clock edge after an event that traps.

Top module: `dbg_bp_unit`

## Requirements
- R1: A slot is enabled when control bit 2i (local) or bit 2i+1 (global) is set. A disabled slot never raises the exception and never hits on an I/O access.
- R2: Slot i's kind field is control bits [17+4i:16+4i] and its length field is control bits [19+4i:18+4i]. Kind codes: 0 instruction execute, 1 data write, 2 I/O read/write, 3 data read/write.
- R3: The length code maps to a window of 1 byte (code 0), 2 bytes (code 1), 8 bytes (code 2) or 4 bytes (code 3).
- R4: On a check, an instruction-kind slot matches when its address equals the instruction pointer. An I/O-kind slot never matches on a check.
- R5: On a check, a data-write or data-read/write slot matches when its watch-hit flag is set. Watch-hit flags of instruction or I/O slots are ignored.
- R6: A check in which at least one enabled slot matches replaces status bits 3:0 with the set of all matching slots, enabled or not, and traps. A check with no enabled match leaves the status unchanged and does not trap.
- R7: A single-step request replaces status bits 3:0 with the matching set, even when that set is empty. It sets the single-step status bit and always traps. The single-step bit then stays set until reset.
- R8: An I/O access at port P of size S (1 to 4) hits an enabled I/O slot with address A and window L when P+S-1 >= A and P <= A+L-1, computed without wrap. Any hit replaces status bits 3:0 with the hit set and traps. No hit, or size 0, changes nothing.
- R9: When events coincide, single-step wins over I/O access, and I/O access wins over a check.
- R10: The exception output is high for exactly the one cycle after a trapping event and low otherwise.
- R11: Synchronous reset clears the status hit bits, the single-step bit and the exception output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_addr | input | 4x32 | Slot address registers, index = slot |
| bp_ctrl | input | 32 | Packed enable/kind/length control word |
| chk_valid | input | 1 | Ordinary breakpoint check this cycle |
| cur_ip | input | 32 | Current instruction pointer |
| watch_hit | input | 4 | Per-slot data watch-hit flags |
| io_valid | input | 1 | I/O port access this cycle |
| io_port | input | 32 | Accessed port number |
| io_size | input | 3 | Access size in bytes |
| step_req | input | 1 | Single-step event |
| stat_hits | output | 4 | Debug status bits 3:0 (slot hits) |
| stat_step | output | 1 | Debug status single-step bit (bit 14) |
| dbg_exc | output | 1 | Debug exception pulse |

## Verification
Every cycle, the assertions check the following. A pulse on the exception output is always preceded by an event. A step always yields a trap with the step bit set, and the step bit is sticky. The hit bits hold steady when no event arrives. An I/O hit loads exactly the I/O hit set. A check with no enabled match produces no trap. The field positions, the non-linear length code and the overlap boundaries can only be shown by the bench's directed scenarios. The same holds for the enabled-versus-reported split and for the event priority. The bench uses windows and ports placed one byte inside and one byte outside each edge.

// File: rtl/dbgbp_pkg.sv
package dbgbp_pkg;

    localparam int NSLOT    = 4;
    localparam int AW       = 32;
    localparam int CW       = 32;
    localparam int KIND_SH  = 16;
    localparam int LEN_SH   = 18;
    localparam int SLOT_STR = 4;
    localparam int STEP_POS = 14;

    typedef enum logic [1:0] {
        BK_EXEC = 2'd0,
        BK_DWR  = 2'd1,
        BK_IO   = 2'd2,
        BK_DRW  = 2'd3
    } bp_kind_e;

    typedef struct packed {
        logic     en;
        bp_kind_e kind;
        logic [3:0] nbytes;
    } slot_cfg_t;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_CHK  = 2'd1,
        EV_IO   = 2'd2,
        EV_STEP = 2'd3
    } ev_sel_e;

    function automatic logic [3:0] len_to_bytes(input logic [1:0] code);
        case (code)
            2'd0:    len_to_bytes = 4'd1;
            2'd1:    len_to_bytes = 4'd2;
            2'd2:    len_to_bytes = 4'd8;
            default: len_to_bytes = 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/dbgbp_decode.sv
module dbgbp_decode
    import dbgbp_pkg::*;
#(
    parameter int N = NSLOT
) (
    input  logic [CW-1:0]   ctrl,
    output slot_cfg_t       cfg [N]
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        localparam int KPOS = KIND_SH + SLOT_STR * i;
        localparam int LPOS = LEN_SH + SLOT_STR * i;
        always_comb begin
            cfg[i].en     = ctrl[2*i] | ctrl[2*i+1];
            cfg[i].kind   = bp_kind_e'(ctrl[KPOS +: 2]);
            cfg[i].nbytes = len_to_bytes(ctrl[LPOS +: 2]);
        end
    end
endmodule

// File: rtl/dbgbp_match.sv
module dbgbp_match
    import dbgbp_pkg::*;
#(
    parameter int N = NSLOT
) (
    input  slot_cfg_t            cfg [N],
    input  logic [N-1:0][AW-1:0] addr,
    input  logic [AW-1:0]        ip,
    input  logic [N-1:0]         watch,
    input  logic [AW-1:0]        port,
    input  logic [2:0]           size,
    output logic [N-1:0]         chk_match,
    output logic [N-1:0]         en_vec,
    output logic [N-1:0]         io_hit
);
    logic [AW:0] acc_lo, acc_hi;
    logic        size_ok;

    always_comb begin
        size_ok = (size != 3'd0);
        acc_lo  = {1'b0, port};
        acc_hi  = acc_lo + (AW+1)'(size) - (AW+1)'(1);
    end

    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic [AW:0] win_lo, win_hi;
        always_comb begin
            win_lo    = {1'b0, addr[i]};
            win_hi    = win_lo + (AW+1)'(cfg[i].nbytes) - (AW+1)'(1);
            en_vec[i] = cfg[i].en;
            case (cfg[i].kind)
                BK_EXEC:        chk_match[i] = (addr[i] == ip);
                BK_DWR, BK_DRW: chk_match[i] = watch[i];
                default:        chk_match[i] = 1'b0;
            endcase
            io_hit[i] = cfg[i].en && (cfg[i].kind == BK_IO) && size_ok
                        && (acc_hi >= win_lo) && (acc_lo <= win_hi);
        end
    end
endmodule

// File: rtl/dbgbp_status.sv
module dbgbp_status
    import dbgbp_pkg::*;
#(
    parameter int N = NSLOT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         chk_valid,
    input  logic         io_valid,
    input  logic         step_req,
    input  logic [N-1:0] chk_match,
    input  logic [N-1:0] en_vec,
    input  logic [N-1:0] io_hit,
    output logic [N-1:0] hits_q,
    output logic         step_q,
    output logic         exc_q
);
    ev_sel_e      sel;
    logic [N-1:0] hits_d;
    logic         step_d, exc_d;

    always_comb begin
        if (step_req)       sel = EV_STEP;
        else if (io_valid)  sel = EV_IO;
        else if (chk_valid) sel = EV_CHK;
        else                sel = EV_NONE;
    end

    always_comb begin
        hits_d = hits_q;
        step_d = step_q;
        exc_d  = 1'b0;
        case (sel)
            EV_STEP: begin
                hits_d = chk_match;
                step_d = 1'b1;
                exc_d  = 1'b1;
            end
            EV_IO: if (|io_hit) begin
                hits_d = io_hit;
                exc_d  = 1'b1;
            end
            EV_CHK: if (|(chk_match & en_vec)) begin
                hits_d = chk_match;
                exc_d  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hits_q <= '0;
            step_q <= 1'b0;
            exc_q  <= 1'b0;
        end else begin
            hits_q <= hits_d;
            step_q <= step_d;
            exc_q  <= exc_d;
        end
    end
endmodule

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit
    import dbgbp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSLOT-1:0][AW-1:0] bp_addr,
    input  logic [CW-1:0]            bp_ctrl,
    input  logic                     chk_valid,
    input  logic [AW-1:0]            cur_ip,
    input  logic [NSLOT-1:0]         watch_hit,
    input  logic                     io_valid,
    input  logic [AW-1:0]            io_port,
    input  logic [2:0]               io_size,
    input  logic                     step_req,
    output logic [NSLOT-1:0]         stat_hits,
    output logic                     stat_step,
    output logic                     dbg_exc
);
    slot_cfg_t        cfg [NSLOT];
    logic [NSLOT-1:0] chk_match, en_vec, io_hit;

    dbgbp_decode #(.N(NSLOT)) u_dec (
        .ctrl (bp_ctrl),
        .cfg  (cfg)
    );

    dbgbp_match #(.N(NSLOT)) u_match (
        .cfg       (cfg),
        .addr      (bp_addr),
        .ip        (cur_ip),
        .watch     (watch_hit),
        .port      (io_port),
        .size      (io_size),
        .chk_match (chk_match),
        .en_vec    (en_vec),
        .io_hit    (io_hit)
    );

    dbgbp_status #(.N(NSLOT)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .chk_valid (chk_valid),
        .io_valid  (io_valid),
        .step_req  (step_req),
        .chk_match (chk_match),
        .en_vec    (en_vec),
        .io_hit    (io_hit),
        .hits_q    (stat_hits),
        .step_q    (stat_step),
        .exc_q     (dbg_exc)
    );
endmodule

// File: rtl/dbgbp_chk.sv
module dbgbp_chk
    import dbgbp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             chk_valid,
    input logic             io_valid,
    input logic             step_req,
    input logic [NSLOT-1:0] chk_match,
    input logic [NSLOT-1:0] en_vec,
    input logic [NSLOT-1:0] io_hit,
    input logic [NSLOT-1:0] stat_hits,
    input logic             stat_step,
    input logic             dbg_exc
);
    assert_exc_after_event_R10: assert property (@(posedge clk) disable iff (rst)
        dbg_exc |-> $past(step_req || io_valid || chk_valid));

    assert_step_traps_R7: assert property (@(posedge clk) disable iff (rst)
        step_req |=> (dbg_exc && stat_step));

    assert_step_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        stat_step |=> stat_step);

    assert_hits_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(step_req || io_valid || chk_valid) |=> $stable(stat_hits));

    assert_io_load_R8: assert property (@(posedge clk) disable iff (rst)
        (io_valid && !step_req && (io_hit != '0)) |=> (stat_hits == $past(io_hit)));

    assert_no_enabled_no_trap_R6: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !io_valid && !step_req && ((chk_match & en_vec) == '0)) |=> !dbg_exc);
endmodule

bind dbg_bp_unit dbgbp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .chk_valid (chk_valid),
    .io_valid  (io_valid),
    .step_req  (step_req),
    .chk_match (chk_match),
    .en_vec    (en_vec),
    .io_hit    (io_hit),
    .stat_hits (stat_hits),
    .stat_step (stat_step),
    .dbg_exc   (dbg_exc)
);

// File: tb/sim_dbg_bp_unit.sv
module sim_dbg_bp_unit;
    logic             clk = 1'b0;
    logic             rst;
    logic [3:0][31:0] bp_addr;
    logic [31:0]      bp_ctrl;
    logic             chk_valid;
    logic [31:0]      cur_ip;
    logic [3:0]       watch_hit;
    logic             io_valid;
    logic [31:0]      io_port;
    logic [2:0]       io_size;
    logic             step_req;
    logic [3:0]       stat_hits;
    logic             stat_step;
    logic             dbg_exc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dbg_bp_unit u0 (.*);

    // enable bits (local=1, global=2), kind at 16+4i, length at 18+4i
    function automatic logic [31:0] ctl(input int s, input int en, input int kind, input int len);
        ctl = (32'(en) << (2*s)) | (32'(kind) << (16 + 4*s)) | (32'(len) << (18 + 4*s));
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        chk_valid = 0; io_valid = 0; step_req = 0; watch_hit = 0;
    endtask

    // apply one event for one clock, then sample at the next falling edge
    task automatic evt(input bit c, input bit io, input bit st);
        chk_valid = c; io_valid = io; step_req = st;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic expect_out(input string req, input logic [3:0] h, input bit s, input bit e);
        check({req, " hits"}, 32'(stat_hits), 32'(h));
        check({req, " step"}, 32'(stat_step), 32'(s));
        check({req, " exc"},  32'(dbg_exc),   32'(e));
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs();
        bp_addr = '0; bp_ctrl = 0; cur_ip = 0; io_port = 0; io_size = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        expect_out("R11 reset", 4'h0, 0, 0);
    endtask

    task automatic t_exec();
        bp_ctrl = ctl(0, 1, 0, 0);
        bp_addr[0] = 32'h1000; cur_ip = 32'h1000;
        evt(1, 0, 0);
        expect_out("R4 exec match", 4'b0001, 0, 1);
        @(negedge clk);
        check("R10 pulse ends", 32'(dbg_exc), 0);
        cur_ip = 32'h1004;
        evt(1, 0, 0);
        expect_out("R4 exec miss", 4'b0001, 0, 0);
    endtask

    task automatic t_enable();
        bp_ctrl = ctl(1, 0, 0, 0) | ctl(2, 2, 0, 0);
        bp_addr[1] = 32'h2000; bp_addr[2] = 32'h2000; cur_ip = 32'h2000;
        evt(1, 0, 0);
        expect_out("R1 R6 global enable, disabled reported", 4'b0110, 0, 1);
        bp_ctrl = ctl(1, 0, 0, 0);
        evt(1, 0, 0);
        expect_out("R6 only disabled match", 4'b0110, 0, 0);
    endtask

    task automatic t_data();
        for (int i = 0; i < 4; i++) bp_addr[i] = 32'hDEAD_0000 + 32'(i);
        bp_ctrl = ctl(3, 1, 1, 0) | ctl(0, 2, 3, 0) | ctl(2, 1, 0, 0);
        watch_hit = 4'b1101;
        evt(1, 0, 0);
        expect_out("R5 R2 data kinds match", 4'b1001, 0, 1);
        bp_ctrl = ctl(1, 1, 2, 0);
        watch_hit = 4'b0010;
        evt(1, 0, 0);
        expect_out("R5 io slot ignores watch", 4'b1001, 0, 0);
    endtask

    task automatic io_evt(input logic [31:0] p, input logic [2:0] s);
        io_port = p; io_size = s;
        evt(0, 1, 0);
    endtask

    task automatic t_io();
        bp_ctrl = ctl(1, 1, 2, 2) | ctl(3, 2, 2, 3) | ctl(0, 1, 2, 1) | ctl(2, 0, 2, 0);
        bp_addr[1] = 32'h100; bp_addr[3] = 32'h200; bp_addr[0] = 32'h300; bp_addr[2] = 32'h400;
        io_evt(32'h203, 1); expect_out("R3 R8 len4 last byte", 4'b1000, 0, 1);
        io_evt(32'h204, 1); expect_out("R3 R8 len4 past end", 4'b1000, 0, 0);
        io_evt(32'h0FE, 2); expect_out("R8 below start", 4'b1000, 0, 0);
        io_evt(32'h0FE, 4); expect_out("R8 size overlap", 4'b0010, 0, 1);
        io_evt(32'h108, 1); expect_out("R3 R8 len8 past end", 4'b0010, 0, 0);
        io_evt(32'h107, 1); expect_out("R3 R8 len8 last byte", 4'b0010, 0, 1);
        io_evt(32'h301, 1); expect_out("R3 R8 len2 last byte", 4'b0001, 0, 1);
        io_evt(32'h302, 1); expect_out("R3 R8 len2 past end", 4'b0001, 0, 0);
        io_evt(32'h400, 1); expect_out("R1 R8 disabled io slot", 4'b0001, 0, 0);
        io_evt(32'h300, 0); expect_out("R8 size zero", 4'b0001, 0, 0);
    endtask

    task automatic t_step();
        bp_ctrl = 0;
        cur_ip = 32'h5000; bp_addr[0] = 32'h9000;
        evt(0, 0, 1);
        expect_out("R7 step empty", 4'b0000, 1, 1);
        @(negedge clk);
        expect_out("R7 R10 step sticky", 4'b0000, 1, 0);
        bp_addr[0] = 32'h5000;
        evt(0, 0, 1);
        expect_out("R7 step reports disabled match", 4'b0001, 1, 1);
    endtask

    task automatic t_prio();
        bp_ctrl = ctl(1, 1, 0, 0) | ctl(2, 1, 2, 0);
        bp_addr[0] = 32'h7777; bp_addr[1] = 32'h6000; bp_addr[2] = 32'h50;
        cur_ip = 32'h6000; io_port = 32'h50; io_size = 1;
        evt(1, 1, 1);
        expect_out("R9 step wins", 4'b0010, 1, 1);
        evt(1, 1, 0);
        expect_out("R9 io over check", 4'b0100, 1, 1);
        evt(1, 0, 0);
        expect_out("R9 check alone", 4'b0010, 1, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_exec();
        t_enable();
        t_data();
        t_io();
        t_step();
        t_prio();
        t_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule